// File: doc/BRIEF.md
# Parallel ROM read timing controller

This block sits on the system-clock side of an asynchronous parallel ROM. That ROM has no clock of its own. A read request carries a byte address and a byte/word flag, and it arrives on a valid/ready handshake. For each request the controller drives the ROM address, the active-low chip-enable and output-enable strobes, and the width-select pin. A byte read also drives the shared low-order address pin. The controller counts clock cycles until the slowest of three access paths has settled. It then samples the data bus and returns the result with a one-cycle valid pulse.

Each analog delay is a nanosecond parameter. The block turns it into a clock count by rounding up against the clock-period parameter. The access paths are address-to-data, chip-enable-to-data and output-enable-to-data. The recovery delays are bus float after the strobes rise and the minimum read-cycle length. The sequence runs through idle, setup, access, capture and recovery. The next request is taken only after the ROM data bus has had time to float and the read-cycle minimum has been met.

Top module: `prom_rd_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, both enables are high (1), `rsp_valid` is 0 and `rsp_data` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From that edge until recovery ends, `req_ready` is 0. A request presented while `req_ready` is 0 has no effect on the ROM pins and produces no response.
- R3: In the cycle after acceptance, `rom_ce_n` is 0 and `rom_oe_n` is 1. `rom_oe_n` falls one cycle later. `rom_oe_n` is never 0 while `rom_ce_n` is 1.
- R4: The bus is sampled at the edge LAT cycles after acceptance. LAT is the largest of ceil(T_AA/Tclk), ceil(T_ACE/Tclk) and ceil(T_OE/Tclk)+1, with a floor of 3; the defaults give 8. `rsp_valid` is 1 in exactly that one cycle.
- R5: `rom_addr` is set to `req_addr[AW:1]` at acceptance. It stays unchanged while chip enable is low and through recovery.
- R6: A byte request (`req_byte`=1) drives `rom_word` to 0, sets `rom_lsb_oe` to 1 and puts `req_addr[0]` on `rom_lsb`. The result is `{8'h00, rom_dq[7:0]}`.
- R7: A word request (`req_byte`=0) drives `rom_word` to 1 and sets `rom_lsb_oe` to 0. The result is `rom_dq[15:0]`.
- R8: After capture, both enables stay high for REC cycles before `req_ready` returns to 1. REC is the largest of ceil(T_FLT/Tclk), ceil(T_RC/Tclk)-LAT and 1; the defaults give 3.
- R9: `rsp_data` keeps its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | AW+1 | Byte address of the read |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid | output | 1 | One-cycle pulse: rsp_data is new |
| rsp_data | output | DW | Read result, zero-extended for byte reads |
| rom_addr | output | AW | Word address to the ROM |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_word | output | 1 | ROM width select, 1 = word |
| rom_lsb | output | 1 | Byte-select address bit for the shared pin |
| rom_lsb_oe | output | 1 | Drive enable for the shared pin |
| rom_dq | input | DW | ROM data bus |

## Verification
The hardest case to reach is a capture made one cycle too early. The ROM's pins look the same either way, so early sampling can only show up through the data. The bench ROM model returns a garbage pattern until its own age counters for address, chip enable and output enable have each covered their delay. Each read also compares the per-cycle strobe and ready pattern against LAT and REC. A second request raised in the middle of a busy read shows that the address bus and the response ignore it.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_CAPTURE,
        ST_RECOVER
    } rd_state_e;

    // nanoseconds to whole clock cycles, rounded up
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prom_rd_timer.sv
module prom_rd_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/prom_rd_pins.sv
module prom_rd_pins
    import prom_rd_pkg::*;
#(
    parameter int AW = 21
) (
    input  rd_state_e     state,
    input  logic [AW:0]   addr_q,
    input  logic          byte_q,
    output logic [AW-1:0] rom_addr,
    output logic          rom_ce_n,
    output logic          rom_oe_n,
    output logic          rom_word,
    output logic          rom_lsb,
    output logic          rom_lsb_oe,
    output logic          req_ready
);
    always_comb begin
        rom_ce_n = 1'b1;
        rom_oe_n = 1'b1;
        unique case (state)
            ST_SETUP:   rom_ce_n = 1'b0;
            ST_ACCESS,
            ST_CAPTURE: begin
                rom_ce_n = 1'b0;
                rom_oe_n = 1'b0;
            end
            default: ;
        endcase
    end

    // address and width select are held from acceptance to the next one
    assign rom_addr   = addr_q[AW:1];
    assign rom_word   = ~byte_q;
    assign rom_lsb_oe = byte_q;
    assign rom_lsb    = byte_q & addr_q[0];
    assign req_ready  = (state == ST_IDLE);
endmodule

// File: rtl/prom_rd_fmt.sv
module prom_rd_fmt #(
    parameter int DW = 16
) (
    input  logic          byte_mode,
    input  logic [DW-1:0] dq,
    output logic [DW-1:0] data
);
    localparam int BW = DW / 2;

    always_comb begin
        if (byte_mode) begin
            data = {{(DW-BW){1'b0}}, dq[BW-1:0]};
        end else begin
            data = dq;
        end
    end
endmodule

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl
    import prom_rd_pkg::*;
#(
    parameter int AW        = 21,
    parameter int DW        = 16,
    parameter int CLK_NS    = 20,
    parameter int T_RC_NS   = 150,
    parameter int T_AA_NS   = 150,
    parameter int T_ACE_NS  = 150,
    parameter int T_OE_NS   = 70,
    parameter int T_FLT_NS  = 60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW:0]   req_addr,
    input  logic          req_byte,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] rom_addr,
    output logic          rom_ce_n,
    output logic          rom_oe_n,
    output logic          rom_word,
    output logic          rom_lsb,
    output logic          rom_lsb_oe,
    input  logic [DW-1:0] rom_dq
);
    localparam int C_AA  = ns_to_cyc(T_AA_NS,  CLK_NS);
    localparam int C_CE  = ns_to_cyc(T_ACE_NS, CLK_NS);
    localparam int C_OE  = ns_to_cyc(T_OE_NS,  CLK_NS);
    localparam int C_RC  = ns_to_cyc(T_RC_NS,  CLK_NS);
    localparam int C_FLT = ns_to_cyc(T_FLT_NS, CLK_NS);
    // cycles from acceptance edge to sample edge; OE starts one cycle late
    localparam int W_ACC = imax(imax(C_AA, C_CE), C_OE + 1);
    localparam int N_ACC = imax(W_ACC - 2, 1);
    localparam int N_REC = imax(imax(C_FLT, C_RC - (N_ACC + 2)), 1);
    localparam int CW    = $clog2(imax(N_ACC, N_REC) + 1);

    typedef struct packed {
        rd_state_e     st;
        logic [AW:0]   addr;
        logic          byte_m;
        logic [DW-1:0] data;
        logic          valid;
    } ctrl_t;

    ctrl_t         s_d, s_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic [DW-1:0] fmt_data;

    prom_rd_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    prom_rd_fmt #(.DW(DW)) fmt_i (
        .byte_mode (s_q.byte_m),
        .dq        (rom_dq),
        .data      (fmt_data)
    );

    prom_rd_pins #(.AW(AW)) pins_i (
        .state      (s_q.st),
        .addr_q     (s_q.addr),
        .byte_q     (s_q.byte_m),
        .rom_addr   (rom_addr),
        .rom_ce_n   (rom_ce_n),
        .rom_oe_n   (rom_oe_n),
        .rom_word   (rom_word),
        .rom_lsb    (rom_lsb),
        .rom_lsb_oe (rom_lsb_oe),
        .req_ready  (req_ready)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.addr   = req_addr;
                    s_d.byte_m = req_byte;
                    s_d.st     = ST_SETUP;
                    tmr_load   = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    s_d.st   = ST_ACCESS;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(N_ACC - 1);
                end
            end
            ST_ACCESS: begin
                if (tmr_done) begin
                    s_d.st   = ST_CAPTURE;
                    tmr_load = 1'b1;
                end
            end
            ST_CAPTURE: begin
                if (tmr_done) begin
                    s_d.data  = fmt_data;
                    s_d.valid = 1'b1;
                    s_d.st    = ST_RECOVER;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(N_REC - 1);
                end
            end
            ST_RECOVER: begin
                if (tmr_done) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st     <= ST_IDLE;
            s_q.addr   <= '0;
            s_q.byte_m <= 1'b0;
            s_q.data   <= '0;
            s_q.valid  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.valid;
    assign rsp_data  = s_q.data;
endmodule

// File: rtl/prom_rd_ctrl_chk.sv
module prom_rd_ctrl_chk #(
    parameter int AW    = 21,
    parameter int DW    = 16,
    parameter int C_AA  = 8,
    parameter int C_CE  = 8,
    parameter int C_OE  = 4,
    parameter int C_FLT = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic [AW-1:0] rom_addr,
    input logic          rom_ce_n,
    input logic          rom_oe_n,
    input logic          rom_word,
    input logic          rom_lsb_oe
);
    localparam int SAT = 1000000;

    int ce_lo_q, oe_lo_q, ce_hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_lo_q <= 0;
            oe_lo_q <= 0;
            ce_hi_q <= SAT;
        end else begin
            ce_lo_q <= rom_ce_n ? 0 : ((ce_lo_q < SAT) ? ce_lo_q + 1 : SAT);
            oe_lo_q <= rom_oe_n ? 0 : ((oe_lo_q < SAT) ? oe_lo_q + 1 : SAT);
            ce_hi_q <= !rom_ce_n ? 0 : ((ce_hi_q < SAT) ? ce_hi_q + 1 : SAT);
        end
    end

    // R3
    oe_under_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> !rom_ce_n);

    // R3
    oe_after_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_oe_n) |-> $past(!rom_ce_n));

    // R4
    access_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (ce_lo_q >= C_CE && ce_lo_q >= C_AA && oe_lo_q >= C_OE));

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    busy_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_addr));

    // R8
    float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_ce_n) |-> ce_hi_q >= C_FLT);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rom_ce_n && rom_oe_n));

    // R6
    lsb_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && !rom_word) |-> rom_lsb_oe);

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $stable(rsp_data));
endmodule

bind prom_rd_ctrl prom_rd_ctrl_chk #(
    .AW    (AW),
    .DW    (DW),
    .C_AA  (C_AA),
    .C_CE  (C_CE),
    .C_OE  (C_OE),
    .C_FLT (C_FLT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rom_addr   (rom_addr),
    .rom_ce_n   (rom_ce_n),
    .rom_oe_n   (rom_oe_n),
    .rom_word   (rom_word),
    .rom_lsb_oe (rom_lsb_oe)
);

// File: tb/prom_rd_ctrl_tb.sv
module prom_rd_ctrl_tb_top;
    localparam int AW   = 21;
    localparam int DW   = 16;
    localparam int TCLK = 20;
    // expected cycle counts, worked out from the requirements
    localparam int CAA  = (150 + TCLK - 1) / TCLK;
    localparam int CCE  = (150 + TCLK - 1) / TCLK;
    localparam int COE  = (70 + TCLK - 1) / TCLK;
    localparam int CRC  = (150 + TCLK - 1) / TCLK;
    localparam int CFL  = (60 + TCLK - 1) / TCLK;
    localparam int LAT0 = (CAA > CCE) ? CAA : CCE;
    localparam int LAT1 = (LAT0 > COE + 1) ? LAT0 : COE + 1;
    localparam int LAT  = (LAT1 < 3) ? 3 : LAT1;
    localparam int REC0 = (CFL > CRC - LAT) ? CFL : CRC - LAT;
    localparam int REC  = (REC0 < 1) ? 1 : REC0;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [AW:0]   req_addr;
    logic          req_byte;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] rom_addr;
    logic          rom_ce_n, rom_oe_n, rom_word, rom_lsb, rom_lsb_oe;
    logic [DW-1:0] rom_dq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(TCLK/2) clk = ~clk;

    prom_rd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
        .rom_oe_n(rom_oe_n), .rom_word(rom_word), .rom_lsb(rom_lsb),
        .rom_lsb_oe(rom_lsb_oe), .rom_dq(rom_dq)
    );

    // ROM model: shows garbage until every access interval has run out
    function automatic logic [15:0] wfun(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'h96, a[15:8] ^ a[20:13] ^ 8'h1E};
    endfunction

    int ce_age = 0, oe_age = 0, a_age = 0;
    logic [AW-1:0] pa = '0;
    logic          pl = 1'b0;

    always @(posedge clk) begin
        ce_age <= rom_ce_n ? 0 : ce_age + 1;
        oe_age <= rom_oe_n ? 0 : oe_age + 1;
        a_age  <= (rom_addr != pa || rom_lsb != pl) ? 1 : a_age + 1;
        pa     <= rom_addr;
        pl     <= rom_lsb;
    end

    always_comb begin
        logic [15:0] w;
        w = wfun(rom_addr);
        if (rom_ce_n || rom_oe_n || ce_age < CCE - 1 || oe_age < COE - 1 || a_age < CAA - 1)
            rom_dq = 16'hE7E7;
        else if (rom_word)
            rom_dq = w;
        else
            rom_dq = {8'hC3, rom_lsb ? w[15:8] : w[7:0]};
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one full read, checked cycle by cycle; poke_at > 0 raises a stray request then
    task automatic run_read(input logic [AW:0] a, input logic b, input int poke_at,
                            output logic [15:0] got);
        logic [15:0] w, expd;
        int bad_en = 0, bad_rdy = 0, bad_v = 0, bad_addr = 0;
        w    = wfun(a[AW:1]);
        expd = b ? {8'h00, a[0] ? w[15:8] : w[7:0]} : w;
        got  = 16'h0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_byte = b;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R3 strobes after accept", {30'd0, rom_ce_n, rom_oe_n}, 32'b01);
        check("R5 address driven", rom_addr, a[AW:1]);
        check(b ? "R6 width pin" : "R7 width pin", rom_word, !b);
        check(b ? "R6 lsb drive" : "R7 lsb release", rom_lsb_oe, b);
        if (b) check("R6 lsb value", rom_lsb, a[0]);
        for (int k = 1; k <= LAT + REC; k++) begin
            if (poke_at > 0 && k == poke_at) begin
                req_valid = 1'b1; req_addr = ~a; req_byte = ~b;
            end
            if (poke_at > 0 && k == poke_at + 1) req_valid = 1'b0;
            @(negedge clk);
            if ({rom_ce_n, rom_oe_n} != ((k < LAT) ? 2'b00 : 2'b11)) bad_en++;
            if (req_ready != (k == LAT + REC)) bad_rdy++;
            if (rsp_valid != (k == LAT)) bad_v++;
            if (rom_addr != a[AW:1]) bad_addr++;
            if (rsp_valid) got = rsp_data;
        end
        req_valid = 1'b0;
        check("R3 R8 strobe pattern mismatches", bad_en, 0);
        check("R2 R8 ready pattern mismatches", bad_rdy, 0);
        check("R4 valid pulse mismatches", bad_v, 0);
        check("R5 address hold mismatches", bad_addr, 0);
        check(b ? "R6 byte data" : "R7 word data", got, expd);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_byte = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 ready in reset", req_ready, 1);
        check("R1 enables in reset", {rom_ce_n, rom_oe_n}, 2'b11);
        check("R1 valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 data after reset", rsp_data, 0);
        check("R1 ready after reset", req_ready, 1);
    endtask

    task automatic t_word();
        logic [15:0] g;
        run_read(22'h0ABCDE, 1'b0, 0, g);
        run_read(22'h3F0F02, 1'b0, 0, g);
    endtask

    task automatic t_byte();
        logic [15:0] g;
        run_read(22'h12344, 1'b1, 0, g);
        check("R6 upper byte zero", g[15:8], 0);
        run_read(22'h12345, 1'b1, 0, g);
        check("R6 upper byte zero odd", g[15:8], 0);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] g;
        run_read(22'h05A5A4, 1'b0, 3, g);
        @(negedge clk);
        check("R2 no read from stray request", rom_ce_n, 1);
    endtask

    task automatic t_hold();
        logic [15:0] g;
        run_read(22'h2468A, 1'b1, 0, g);
        repeat (5) @(negedge clk);
        check("R9 data held", rsp_data, g);
        check("R9 valid low while idle", rsp_valid, 0);
    endtask

    task automatic t_back_to_back();
        logic [15:0] g;
        run_read(22'h1FFFFE, 1'b0, 0, g);
        run_read(22'h000003, 1'b1, 0, g);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_word();
        t_byte();
        t_busy_ignore();
        t_hold();
        t_back_to_back();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule